// File: doc/BRIEF.md
# Spanning-Tree Port State Table

This block holds one record per spanning-tree instance. Each record is a valid flag plus a 2-bit forwarding state for every port. Software reaches the table through a small register window. It places an instance number, a valid flag and packed port states in holding registers, then writes a command word with its busy bit set. The busy bit stays high until the command finishes.

Two commands exist. The first is load/purge. It stores the holding registers under the instance number, or it removes that record when the valid flag is clear. The second is get-next. It scans upward from the instance number in the holding register for the next record that is present. On a hit it copies that instance and its port states back into the holding registers. Issuing get-next again therefore walks all present instances in ascending order.

The instance width and the port count are parameters. The defaults are 6 bits (64 instances) and 11 ports. The block keeps no VLAN data; the binding from VLANs to instances lives elsewhere.

Top module: `stu_state_table`

## Requirements
- R1: After reset every register reads 0 and the table holds no records, so a get-next started from any instance reports not found.
- R2: Writing the command register (address 0) with bit 15 set and a known opcode in bits 14:12 starts a command. The opcodes are 3 for load/purge and 4 for get-next. Reads of address 0 return busy in bit 15 and the last started opcode in bits 14:12. Load/purge keeps busy high for exactly one cycle.
- R3: While busy is set, writes to any register are ignored.
- R4: Load/purge with the valid flag set stores the port states under the instance in the instance register (address 1). A later get-next returns those states unchanged.
- R5: Load/purge with the valid flag clear removes the record, and get-next skips it afterwards.
- R6: Get-next finds the smallest present instance above the instance register. It writes that instance back, sets the valid flag and loads the data registers. When the instance register holds all ones, the search starts again at instance 0.
- R7: When no higher instance is present, get-next clears the valid flag. The instance register and the data registers keep their values.
- R8: Port i's state sits at bits 2*(i mod 8)+1:2*(i mod 8) of data register i/8. Data register 0 is address 3 and data register 1 is address 4. The state codes are 0 disabled, 1 blocking, 2 learning and 3 forwarding.
- R9: State bits of ports at or beyond the configured port count read as 0, and writes to them have no effect.
- R10: The instance register keeps only its low SID_W bits; the upper bits read as 0.
- R11: The valid register (address 2) keeps only the valid flag in bit 12. Its VLAN field and all other bits read as 0.
- R12: A command-register write with bit 15 clear, or with an unknown opcode, starts nothing and changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address, used for both writes and reads |
| wdata | input | 16 | Register write data |
| rdata | output | 16 | Read data of the addressed register (combinational) |

## Verification
Several properties are checked on every cycle. Load lasts a single busy cycle, and busy rises only after a command write. The instance register holds still during a scan. A miss leaves the instance register alone and clears the flag, and a hit lands on a higher instance. The unused bits of the valid register and of data register 1 always read as zero. Only the bench scenarios can show the rest. Those are whether stored states come back bit-exact, whether a purged instance is skipped, whether a full walk visits the instances in ascending order, and whether the search wraps from the all-ones instance back to 0.

// File: rtl/stu_pkg.sv
package stu_pkg;
  localparam int REG_W   = 16;
  localparam int ADDR_W  = 3;
  localparam int BUSY_BIT = 15;
  localparam int OP_LSB  = 12;
  localparam int VLD_BIT = 12;
  localparam int LANES   = REG_W / 2;

  typedef enum logic [ADDR_W-1:0] {
    RA_CMD = 3'd0,
    RA_SID = 3'd1,
    RA_VLD = 3'd2,
    RA_ST0 = 3'd3,
    RA_ST1 = 3'd4
  } reg_addr_e;

  typedef enum logic [2:0] {
    OP_IDLE = 3'd0,
    OP_LOAD = 3'd3,
    OP_NEXT = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    PS_DISABLED   = 2'd0,
    PS_BLOCKING   = 2'd1,
    PS_LEARNING   = 2'd2,
    PS_FORWARDING = 2'd3
  } port_state_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOAD = 2'd1,
    PH_SCAN = 2'd2
  } phase_e;
endpackage

// File: rtl/stu_port_lanes.sv
module stu_port_lanes import stu_pkg::*; #(
  parameter int NPORTS = 11
) (
  input  logic [2*NPORTS-1:0] states_q,
  input  logic [REG_W-1:0]    wdata,
  input  logic                wr_lo,
  input  logic                wr_hi,
  output logic [2*NPORTS-1:0] states_wr,
  output logic [REG_W-1:0]    view_lo,
  output logic [REG_W-1:0]    view_hi
);
  for (genvar p = 0; p < 2*LANES; p++) begin : g_lane
    localparam int OFS = 2 * (p % LANES);
    if (p < NPORTS) begin : g_used
      logic sel;
      assign sel = (p < LANES) ? wr_lo : wr_hi;
      assign states_wr[2*p +: 2] = sel ? wdata[OFS +: 2] : states_q[2*p +: 2];
      if (p < LANES) begin : g_lo
        assign view_lo[OFS +: 2] = states_q[2*p +: 2];
      end else begin : g_hi
        assign view_hi[OFS +: 2] = states_q[2*p +: 2];
      end
    end else begin : g_unused
      if (p < LANES) begin : g_lo
        assign view_lo[OFS +: 2] = 2'b00;
      end else begin : g_hi
        assign view_hi[OFS +: 2] = 2'b00;
      end
    end
  end
endmodule

// File: rtl/stu_table.sv
module stu_table #(
  parameter int SID_W = 6,
  parameter int SW    = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [SID_W-1:0] waddr,
  input  logic             wvalid,
  input  logic [SW-1:0]    wstates,
  input  logic [SID_W-1:0] raddr,
  output logic             rvalid,
  output logic [SW-1:0]    rstates
);
  localparam int DEPTH = 1 << SID_W;

  logic [DEPTH-1:0] present_q;
  logic [SW-1:0]    state_mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  present_q <= '0;
    else if (we) present_q[waddr] <= wvalid;
  end

  always_ff @(posedge clk) begin
    if (we && wvalid) state_mem[waddr] <= wstates;
  end

  assign rvalid  = present_q[raddr];
  assign rstates = state_mem[raddr];
endmodule

// File: rtl/stu_scan_ctrl.sv
module stu_scan_ctrl import stu_pkg::*; #(
  parameter int SID_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  op_e              start_op,
  input  logic [SID_W-1:0] sid_cur,
  input  logic             tbl_hit,
  output logic             busy,
  output op_e              op_q,
  output logic [SID_W-1:0] idx_q,
  output logic             tbl_we,
  output logic             scan_hit,
  output logic             scan_miss
);
  localparam logic [SID_W-1:0] LAST = {SID_W{1'b1}};

  phase_e           ph_q, ph_d;
  op_e              op_d;
  logic [SID_W-1:0] idx_d;

  always_comb begin
    ph_d      = ph_q;
    op_d      = op_q;
    idx_d     = idx_q;
    tbl_we    = 1'b0;
    scan_hit  = 1'b0;
    scan_miss = 1'b0;
    unique case (ph_q)
      PH_IDLE: if (start) begin
        op_d = start_op;
        if (start_op == OP_LOAD) begin
          ph_d = PH_LOAD;
        end else begin
          ph_d  = PH_SCAN;
          idx_d = sid_cur + 1'b1;
        end
      end
      PH_LOAD: begin
        tbl_we = 1'b1;
        ph_d   = PH_IDLE;
      end
      PH_SCAN: begin
        if (tbl_hit) begin
          scan_hit = 1'b1;
          ph_d     = PH_IDLE;
        end else if (idx_q == LAST) begin
          scan_miss = 1'b1;
          ph_d      = PH_IDLE;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      op_q  <= OP_IDLE;
      idx_q <= '0;
    end else begin
      ph_q  <= ph_d;
      op_q  <= op_d;
      idx_q <= idx_d;
    end
  end

  assign busy = (ph_q != PH_IDLE);
endmodule

// File: rtl/stu_state_table.sv
module stu_state_table import stu_pkg::*; #(
  parameter int SID_W  = 6,
  parameter int NPORTS = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata
);
  localparam int SW = 2 * NPORTS;

  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_sync_n, rst_meta} <= 2'b00;
    else        {rst_sync_n, rst_meta} <= {rst_meta, 1'b1};
  end

  logic [SID_W-1:0] sid_q, sid_d;
  logic             vld_q, vld_d;
  logic [SW-1:0]    data_q, data_d, data_wr;
  logic [REG_W-1:0] view_lo, view_hi;

  logic             busy_q, tbl_we, tbl_hit, scan_hit, scan_miss;
  op_e              op_q;
  logic [SID_W-1:0] idx_q;
  logic [SW-1:0]    tbl_states;

  logic wr_ok, start;
  op_e  req_op;

  assign wr_ok  = wr_en && !busy_q;
  assign req_op = op_e'(wdata[OP_LSB +: 3]);
  assign start  = wr_ok && (addr == RA_CMD) && wdata[BUSY_BIT] &&
                  ((req_op == OP_LOAD) || (req_op == OP_NEXT));

  stu_port_lanes #(.NPORTS(NPORTS)) u_lanes (
    .states_q (data_q),
    .wdata    (wdata),
    .wr_lo    (wr_ok && (addr == RA_ST0)),
    .wr_hi    (wr_ok && (addr == RA_ST1)),
    .states_wr(data_wr),
    .view_lo  (view_lo),
    .view_hi  (view_hi)
  );

  stu_scan_ctrl #(.SID_W(SID_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .start    (start),
    .start_op (req_op),
    .sid_cur  (sid_q),
    .tbl_hit  (tbl_hit),
    .busy     (busy_q),
    .op_q     (op_q),
    .idx_q    (idx_q),
    .tbl_we   (tbl_we),
    .scan_hit (scan_hit),
    .scan_miss(scan_miss)
  );

  stu_table #(.SID_W(SID_W), .SW(SW)) u_table (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .we     (tbl_we),
    .waddr  (sid_q),
    .wvalid (vld_q),
    .wstates(data_q),
    .raddr  (idx_q),
    .rvalid (tbl_hit),
    .rstates(tbl_states)
  );

  always_comb begin
    sid_d  = sid_q;
    vld_d  = vld_q;
    data_d = data_wr;
    if (wr_ok && (addr == RA_SID)) sid_d = wdata[SID_W-1:0];
    if (wr_ok && (addr == RA_VLD)) vld_d = wdata[VLD_BIT];
    if (scan_hit) begin
      sid_d  = idx_q;
      vld_d  = 1'b1;
      data_d = tbl_states;
    end
    if (scan_miss) vld_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      sid_q  <= '0;
      vld_q  <= 1'b0;
      data_q <= '0;
    end else begin
      sid_q  <= sid_d;
      vld_q  <= vld_d;
      data_q <= data_d;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      RA_CMD:  rdata = {busy_q, op_q, {(REG_W-4){1'b0}}};
      RA_SID:  rdata[SID_W-1:0] = sid_q;
      RA_VLD:  rdata[VLD_BIT] = vld_q;
      RA_ST0:  rdata = view_lo;
      RA_ST1:  rdata = view_hi;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/stu_state_table_chk.sv
module stu_state_table_chk import stu_pkg::*; #(
  parameter int SID_W  = 6,
  parameter int NPORTS = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [REG_W-1:0]  wdata,
  input logic [REG_W-1:0]  rdata,
  input logic              busy,
  input op_e               op,
  input logic [SID_W-1:0]  sid,
  input logic              vld,
  input logic              hit,
  input logic              miss
);
  localparam int HI_BITS = (NPORTS > LANES) ? 2 * (NPORTS - LANES) : 0;
  localparam logic [31:0] HI_MASK32 = (32'h1 << HI_BITS) - 32'h1;
  localparam logic [REG_W-1:0] HI_MASK = HI_MASK32[REG_W-1:0];
  localparam logic [SID_W-1:0] LAST = {SID_W{1'b1}};

  a_r2_load_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op == OP_LOAD) |=> !busy);

  a_r12_start_needs_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_en && addr == RA_CMD && wdata[BUSY_BIT]));

  a_r3_sid_frozen_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !hit) |=> $stable(sid));

  a_r7_miss_keeps_sid: assert property (@(posedge clk) disable iff (!rst_n)
    miss |=> (!vld && $stable(sid)));

  a_r6_hit_is_higher: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && sid != LAST) |=> (vld && sid > $past(sid)));

  a_r9_unused_ports_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == RA_ST1) |-> ((rdata & ~HI_MASK) == '0));

  a_r11_valid_reg_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == RA_VLD) |-> ((rdata & ~(REG_W'(1) << VLD_BIT)) == '0));
endmodule

bind stu_state_table stu_state_table_chk #(.SID_W(SID_W), .NPORTS(NPORTS)) u_chk (
  .clk  (clk),
  .rst_n(rst_sync_n),
  .wr_en(wr_en),
  .addr (addr),
  .wdata(wdata),
  .rdata(rdata),
  .busy (busy_q),
  .op   (op_q),
  .sid  (sid_q),
  .vld  (vld_q),
  .hit  (scan_hit),
  .miss (scan_miss)
);

// File: tb/stu_state_table_tb.sv
module stu_state_table_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  addr;
  logic [15:0] wdata;
  logic [15:0] rdata;

  int n_chk = 0;
  int n_fail = 0;

  localparam logic [2:0] A_CMD = 3'd0, A_SID = 3'd1, A_VLD = 3'd2, A_ST0 = 3'd3, A_ST1 = 3'd4;
  localparam logic [15:0] C_LOAD = 16'hB000, C_NEXT = 16'hC000;

  always #5 clk = ~clk;

  stu_state_table #(.SID_W(6), .NPORTS(11)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic wait_idle();
    logic [15:0] v;
    for (int i = 0; i < 1000; i++) begin
      rd(A_CMD, v);
      if (!v[15]) return;
      @(negedge clk);
    end
    chk("R2 busy never cleared", 16'h1, 16'h0);
  endtask

  task automatic expect_reg(input string tag, input logic [2:0] a, input logic [15:0] exp);
    logic [15:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic load(input logic [5:0] sid, input logic valid, input logic [15:0] s0, input logic [15:0] s1);
    wr(A_SID, {10'd0, sid});
    wr(A_VLD, valid ? 16'h1000 : 16'h0000);
    wr(A_ST0, s0);
    wr(A_ST1, s1);
    wr(A_CMD, C_LOAD);
    wait_idle();
  endtask

  task automatic next_expect(input string tag, input logic [5:0] sid, input logic [15:0] s0, input logic [15:0] s1);
    wr(A_CMD, C_NEXT);
    wait_idle();
    expect_reg({tag, " sid"}, A_SID, {10'd0, sid});
    expect_reg({tag, " valid"}, A_VLD, 16'h1000);
    expect_reg({tag, " st0"}, A_ST0, s0);
    expect_reg({tag, " st1"}, A_ST1, s1);
  endtask

  task automatic t_reset();
    expect_reg("R1 cmd", A_CMD, 16'h0);
    expect_reg("R1 sid", A_SID, 16'h0);
    expect_reg("R1 vld", A_VLD, 16'h0);
    expect_reg("R1 st0", A_ST0, 16'h0);
    expect_reg("R1 st1", A_ST1, 16'h0);
    wr(A_SID, 16'h003F);
    wr(A_CMD, C_NEXT);
    wait_idle();
    expect_reg("R1 empty table valid", A_VLD, 16'h0);
    expect_reg("R7 sid kept on empty", A_SID, 16'h003F);
  endtask

  task automatic t_masks();
    wr(A_SID, 16'hFFFF);
    expect_reg("R10 sid mask", A_SID, 16'h003F);
    wr(A_VLD, 16'hFFFF);
    expect_reg("R11 valid reg bits", A_VLD, 16'h1000);
    wr(A_ST0, 16'hE4E4);
    expect_reg("R8 st0 packing", A_ST0, 16'hE4E4);
    wr(A_ST1, 16'hFFFF);
    expect_reg("R9 unused ports", A_ST1, 16'h003F);
  endtask

  task automatic t_load_walk();
    logic [15:0] v;
    wr(A_SID, 16'd5); wr(A_VLD, 16'h1000); wr(A_ST0, 16'h1B1B); wr(A_ST1, 16'h0024);
    wr(A_CMD, C_LOAD);
    rd(A_CMD, v);
    chk("R2 busy after load start", v, 16'hB000);
    @(negedge clk);
    rd(A_CMD, v);
    chk("R2 load done in one cycle", v, 16'h3000);
    load(6'd20, 1'b1, 16'hFFFF, 16'h0015);
    load(6'd40, 1'b1, 16'h0001, 16'h0030);
    wr(A_ST0, 16'h0); wr(A_ST1, 16'h0); wr(A_VLD, 16'h0);
    wr(A_SID, 16'h003F);
    next_expect("R6 wrap to first", 6'd5, 16'h1B1B, 16'h0024);
    next_expect("R4 second record", 6'd20, 16'hFFFF, 16'h0015);
    next_expect("R6 third record", 6'd40, 16'h0001, 16'h0030);
    wr(A_CMD, C_NEXT);
    wait_idle();
    expect_reg("R7 end valid", A_VLD, 16'h0);
    expect_reg("R7 end sid", A_SID, 16'd40);
  endtask

  task automatic t_purge();
    load(6'd20, 1'b0, 16'h0, 16'h0);
    wr(A_SID, 16'd5);
    next_expect("R5 purged skipped", 6'd40, 16'h0001, 16'h0030);
  endtask

  task automatic t_busy_ignore();
    logic [15:0] v;
    wr(A_SID, 16'd41);
    wr(A_CMD, C_NEXT);
    rd(A_CMD, v);
    chk("R2 busy during scan", v, 16'hC000);
    wr(A_SID, 16'd3);
    wr(A_ST0, 16'h1234);
    wr(A_VLD, 16'h1000);
    wait_idle();
    expect_reg("R3 sid write ignored", A_SID, 16'd41);
    expect_reg("R3 st0 write ignored", A_ST0, 16'h0001);
    expect_reg("R7 miss valid", A_VLD, 16'h0);
  endtask

  task automatic t_top_edge();
    load(6'd63, 1'b1, 16'hAAAA, 16'h002A);
    wr(A_SID, 16'd62);
    next_expect("R6 highest instance", 6'd63, 16'hAAAA, 16'h002A);
    next_expect("R6 wrap from all ones", 6'd5, 16'h1B1B, 16'h0024);
  endtask

  task automatic t_bad_cmd();
    wr(A_CMD, 16'h3000);
    expect_reg("R12 busy bit clear", A_CMD, 16'h4000);
    wr(A_CMD, 16'h9000);
    expect_reg("R12 unknown opcode", A_CMD, 16'h4000);
    expect_reg("R12 sid untouched", A_SID, 16'd5);
  endtask

  initial begin
    #2_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; addr = 3'd0; wdata = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_masks();
    t_load_walk();
    t_purge();
    t_busy_ignore();
    t_top_edge();
    t_bad_cmd();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule